// File: doc/BRIEF.md
# Display Host Register Interface

This block is the host-facing register slave of an eight-digit 5x7 dot-matrix display controller. A host reaches five storage areas through an 8-bit data bus (separate input, output and output-enable signals), a 5-bit address, a chip enable, write and read strobes, and a flash-select strobe. The areas are:

- a character store with one 8-bit code per digit;
- a flash store with one bit per digit;
- a 4-bit glyph pointer;
- a glyph store of 16 custom glyphs, each 7 rows of 5 dots;
- an 8-bit control word.

The flash-select strobe takes priority over the two section bits. Glyph rows are written and read indirectly, through the pointer.

The bus strobes are sampled on the system clock. A write commits when the write strobe rises while chip enable is low. Reset and the clear command fill the character store with the space code and empty the flash store. Each then keeps the block busy for a fixed number of display-clock ticks, which arrive on a one-cycle enable input. Writes that arrive while the block is busy are dropped and recorded in a sticky error flag. The current control word and flash mask are also output directly, for the display refresh logic.

Top module: `disp_host_regs`

## Requirements
- R1: With `flash_sel_n` low, an access goes to the flash store whatever `addr[4:3]` holds. `addr[2:0]` picks the digit, and only data bit 0 is written. A read returns that bit in bit 0, with bits 7..1 at 0.
- R2: With `flash_sel_n` high, `addr[4:3]` selects the section. 00 is the glyph pointer (data bits 3..0, reads zero-extended). 01 is a glyph row. 11 is the character store. 10 is the control word.
- R3: A write commits only when `wr_n` goes from 0 to 1 while `cs_n` is 0. If `cs_n` is 1 at the rising edge, nothing is stored.
- R4: `data_oe` is 1 exactly while `cs_n` and `rd_n` are both 0. Bits with no storage behind them read as 0.
- R5: A glyph-row access uses `addr[2:0]` as the row (0 to 6) of the glyph named by the pointer. Data bits 4..0 hold the five dots, bit 4 being the leftmost. Row address 7 stores nothing and reads 0.
- R6: Reset sets every character to 0x20, and the flash store and control word to 0x00. It also clears the error flag. `busy` then stays 1 until the third `disp_tick` after reset is released. The glyph pointer and the glyph store keep their contents through reset.
- R7: Writing the control word with bit 7 set fills the character store with 0x20 and clears the flash store. The other control bits are stored as written. Bit 7 reads 1 while busy, and returns to 0 on the third `disp_tick`, which also ends busy.
- R8: A write committed while `busy` is 1 changes no storage and sets `wr_err`. `wr_err` stays set until reset.
- R9: The character store keeps all 8 bits of each written code: ASCII codes when bit 7 is 0, glyph indices when bit 7 is 1. The digit address is `addr[2:0]`, with bit 2 the most significant.
- R10: `ctrl_word` always equals the stored control word. Bit i of `flash_mask` is the flash bit of digit i, where digit 0 is the leftmost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_tick | input | 1 | One-cycle display-clock enable |
| cs_n | input | 1 | Chip enable, active low |
| wr_n | input | 1 | Write strobe, active low; commits on rising edge |
| rd_n | input | 1 | Read strobe, active low |
| flash_sel_n | input | 1 | Flash store select, active low |
| addr | input | 5 | Section bits [4:3], location bits [2:0] |
| data_in | input | 8 | Write data from host |
| data_out | output | 8 | Read data to host |
| data_oe | output | 1 | Bus drive enable |
| busy | output | 1 | Reset or clear sequence in progress |
| wr_err | output | 1 | Sticky flag: a write arrived while busy |
| ctrl_word | output | 8 | Current control word |
| flash_mask | output | 8 | Per-digit flash bits |

## Verification
The bench builds the block with its default parameters: eight digits, sixteen glyphs of seven five-dot rows, and a three-tick busy window. With these values every address combination maps to a real location, except the eighth glyph row. That row is therefore the one out-of-range case the bench can reach. The bench drives `disp_tick` itself, one pulse at a time. This lets it observe `busy` after exactly two ticks and exactly three ticks, for both reset and clear. It also lets it attempt a write inside the clear window.

// File: rtl/disp_regs_pkg.sv
package disp_regs_pkg;

    localparam int DW = 8;
    localparam logic [DW-1:0] BLANK_CODE = 8'h20;

    typedef enum logic [2:0] {
        SEC_FLASH = 3'd0,
        SEC_PTR   = 3'd1,
        SEC_ROW   = 3'd2,
        SEC_CHAR  = 3'd3,
        SEC_CTRL  = 3'd4
    } section_e;

endpackage

// File: rtl/disp_sec_decode.sv
module disp_sec_decode
    import disp_regs_pkg::*;
(
    input  logic       flash_sel_n,
    input  logic [1:0] sec_bits,
    output section_e   sec
);
    // The flash strobe has priority over the section bits.
    always_comb begin
        if (!flash_sel_n) begin
            sec = SEC_FLASH;
        end else begin
            unique case (sec_bits)
                2'b00:   sec = SEC_PTR;
                2'b01:   sec = SEC_ROW;
                2'b11:   sec = SEC_CHAR;
                default: sec = SEC_CTRL;
            endcase
        end
    end
endmodule

// File: rtl/disp_busy_timer.sv
module disp_busy_timer #(
    parameter int TICKS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic tick,
    output logic busy,
    output logic done
);
    localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;
    logic last_tick;

    assign last_tick = t_q.busy && tick && (t_q.cnt == CW'(TICKS - 1));

    always_comb begin
        t_d = t_q;
        if (start) begin
            t_d.busy = 1'b1;
            t_d.cnt  = '0;
        end else if (last_tick) begin
            t_d.busy = 1'b0;
            t_d.cnt  = '0;
        end else if (t_q.busy && tick) begin
            t_d.cnt = t_q.cnt + 1'b1;
        end
    end

    // Leaving reset counts as a start.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q.busy <= 1'b1;
            t_q.cnt  <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign busy = t_q.busy;
    assign done = last_tick;

    p_cnt_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        t_q.cnt <= CW'(TICKS - 1));
    p_idle_cnt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !t_q.busy |-> t_q.cnt == '0);
endmodule

// File: rtl/disp_read_mux.sv
module disp_read_mux
    import disp_regs_pkg::*;
#(
    parameter int DIGITS = 8,
    parameter int PTR_W  = 4,
    parameter int COLS   = 5
) (
    input  logic                         rd_en,
    input  section_e                     sec,
    input  logic [$clog2(DIGITS)-1:0]    digit,
    input  logic                         row_valid,
    input  logic [DIGITS-1:0][DW-1:0]    chars,
    input  logic [DIGITS-1:0]            flash,
    input  logic [DW-1:0]                ctrl,
    input  logic [PTR_W-1:0]             ptr,
    input  logic [COLS-1:0]              row_dots,
    output logic [DW-1:0]                rdata
);
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            unique case (sec)
                SEC_FLASH: rdata = {{(DW-1){1'b0}}, flash[digit]};
                SEC_PTR:   rdata = {{(DW-PTR_W){1'b0}}, ptr};
                SEC_ROW:   rdata = row_valid ? {{(DW-COLS){1'b0}}, row_dots} : '0;
                SEC_CHAR:  rdata = chars[digit];
                default:   rdata = ctrl;
            endcase
        end
    end
endmodule

// File: rtl/disp_host_regs.sv
module disp_host_regs
    import disp_regs_pkg::*;
#(
    parameter int DIGITS      = 8,
    parameter int GLYPHS      = 16,
    parameter int ROWS        = 7,
    parameter int COLS        = 5,
    parameter int CLEAR_TICKS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              disp_tick,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic              flash_sel_n,
    input  logic [4:0]        addr,
    input  logic [7:0]        data_in,
    output logic [7:0]        data_out,
    output logic              data_oe,
    output logic              busy,
    output logic              wr_err,
    output logic [7:0]        ctrl_word,
    output logic [DIGITS-1:0] flash_mask
);
    localparam int DIG_AW = $clog2(DIGITS);
    localparam int PTR_W  = $clog2(GLYPHS);
    localparam int ROW_AW = $clog2(ROWS);
    localparam int CLR_BIT = DW - 1;

    typedef struct packed {
        logic [DIGITS-1:0][DW-1:0] chars;
        logic [DIGITS-1:0]         flash;
        logic [DW-1:0]             ctrl;
        logic                      wr_err;
        logic                      wr_prev;
    } regs_t;

    regs_t r_d, r_q;

    logic [PTR_W-1:0] ptr_q;
    logic [COLS-1:0]  glyph_q [GLYPHS][ROWS];

    section_e          sec;
    logic              wr_edge, wr_ok, clr_start, clr_done, busy_w;
    logic [DIG_AW-1:0] digit;
    logic [ROW_AW-1:0] row;
    logic              row_valid;
    logic [COLS-1:0]   row_dots;

    disp_sec_decode u_dec (
        .flash_sel_n (flash_sel_n),
        .sec_bits    (addr[4:3]),
        .sec         (sec)
    );

    assign digit     = addr[DIG_AW-1:0];
    assign row       = addr[ROW_AW-1:0];
    assign row_valid = (32'(row) < ROWS);
    assign wr_edge   = !r_q.wr_prev && wr_n && !cs_n;
    assign wr_ok     = wr_edge && !busy_w;
    assign clr_start = wr_ok && (sec == SEC_CTRL) && data_in[CLR_BIT];

    disp_busy_timer #(.TICKS(CLEAR_TICKS)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (clr_start),
        .tick  (disp_tick),
        .busy  (busy_w),
        .done  (clr_done)
    );

    always_comb begin
        r_d         = r_q;
        r_d.wr_prev = wr_n;
        if (wr_edge && busy_w) begin
            r_d.wr_err = 1'b1;
        end
        if (clr_done) begin
            r_d.ctrl[CLR_BIT] = 1'b0;
        end
        if (wr_ok) begin
            unique case (sec)
                SEC_FLASH: r_d.flash[digit] = data_in[0];
                SEC_CHAR:  r_d.chars[digit] = data_in;
                SEC_CTRL: begin
                    r_d.ctrl = data_in;
                    if (data_in[CLR_BIT]) begin
                        for (int i = 0; i < DIGITS; i++) begin
                            r_d.chars[i] = BLANK_CODE;
                        end
                        r_d.flash = '0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.chars   <= {DIGITS{BLANK_CODE}};
            r_q.flash   <= '0;
            r_q.ctrl    <= '0;
            r_q.wr_err  <= 1'b0;
            r_q.wr_prev <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    // Pointer and glyph rows survive reset, so they carry no reset term.
    always_ff @(posedge clk) begin
        if (wr_ok && sec == SEC_PTR) begin
            ptr_q <= data_in[PTR_W-1:0];
        end
        if (wr_ok && sec == SEC_ROW && row_valid) begin
            glyph_q[ptr_q][row] <= data_in[COLS-1:0];
        end
    end

    assign row_dots = row_valid ? glyph_q[ptr_q][row] : '0;

    disp_read_mux #(.DIGITS(DIGITS), .PTR_W(PTR_W), .COLS(COLS)) u_rmux (
        .rd_en     (data_oe),
        .sec       (sec),
        .digit     (digit),
        .row_valid (row_valid),
        .chars     (r_q.chars),
        .flash     (r_q.flash),
        .ctrl      (r_q.ctrl),
        .ptr       (ptr_q),
        .row_dots  (row_dots),
        .rdata     (data_out)
    );

    assign data_oe    = !cs_n && !rd_n;
    assign busy       = busy_w;
    assign wr_err     = r_q.wr_err;
    assign ctrl_word  = r_q.ctrl;
    assign flash_mask = r_q.flash;

    p_busy_write_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_edge && busy_w) |=> r_q.wr_err);
    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.wr_err |=> r_q.wr_err);
    p_busy_keeps_chars_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_w && !clr_start) |=> $stable(r_q.chars));
    p_clear_bit_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_w) |-> !r_q.ctrl[CLR_BIT]);
    p_flash_one_digit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && sec == SEC_FLASH) |=> $countones(r_q.flash ^ $past(r_q.flash)) <= 1);
    p_ptr_only_own_section_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && sec != SEC_PTR) |=> $stable(ptr_q));
    p_bus_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || rd_n) |-> data_out == '0);
endmodule

// File: tb/tb_disp_host_regs.sv
`timescale 1ns/1ps
module tb_disp_host_regs;

    logic       clk = 1'b0;
    logic       rst_n, disp_tick, cs_n, wr_n, rd_n, flash_sel_n;
    logic [4:0] addr;
    logic [7:0] data_in, data_out, ctrl_word, flash_mask;
    logic       data_oe, busy, wr_err;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    disp_host_regs dut (
        .clk(clk), .rst_n(rst_n), .disp_tick(disp_tick), .cs_n(cs_n),
        .wr_n(wr_n), .rd_n(rd_n), .flash_sel_n(flash_sel_n), .addr(addr),
        .data_in(data_in), .data_out(data_out), .data_oe(data_oe),
        .busy(busy), .wr_err(wr_err), .ctrl_word(ctrl_word),
        .flash_mask(flash_mask)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic fl_n, input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        flash_sel_n = fl_n; addr = a; data_in = d; cs_n = 1'b0; wr_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk);
        cs_n = 1'b1;
    endtask

    task automatic bus_read(input logic fl_n, input logic [4:0] a, output logic [7:0] v);
        @(negedge clk);
        flash_sel_n = fl_n; addr = a; cs_n = 1'b0; rd_n = 1'b0;
        #1 v = data_out;
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b1;
    endtask

    task automatic pulse_tick();
        @(negedge clk); disp_tick = 1'b1;
        @(negedge clk); disp_tick = 1'b0;
    endtask

    task automatic expect_busy_window(input string tag);
        pulse_tick(); pulse_tick();
        check(busy == 1'b1, {tag, " busy after two ticks"}, busy, 1);
        pulse_tick();
        check(busy == 1'b0, {tag, " busy after third tick"}, busy, 0);
    endtask

    task automatic t_reset_state();
        logic [7:0] v;
        check(busy == 1'b1, "R6 busy after reset release", busy, 1);
        expect_busy_window("R6");
        for (int i = 0; i < 8; i++) begin
            bus_read(1'b1, {2'b11, 3'(i)}, v);
            check(v == 8'h20, "R6 char blank after reset", v, 8'h20);
        end
        check(ctrl_word == 8'h00, "R6 ctrl cleared", ctrl_word, 0);
        check(flash_mask == 8'h00, "R6 flash cleared", flash_mask, 0);
        check(wr_err == 1'b0, "R6 wr_err cleared", wr_err, 0);
    endtask

    task automatic t_char_store();
        logic [7:0] v;
        for (int i = 0; i < 8; i++) bus_write(1'b1, {2'b11, 3'(i)}, 8'h41 + 8'(i));
        bus_write(1'b1, 5'b11_011, 8'h8A);
        for (int i = 0; i < 8; i++) begin
            bus_read(1'b1, {2'b11, 3'(i)}, v);
            check(v == ((i == 3) ? 8'h8A : 8'h41 + 8'(i)), "R9 char readback", v,
                  (i == 3) ? 8'h8A : 8'h41 + i);
        end
    endtask

    task automatic t_flash_store();
        logic [7:0] v;
        bus_write(1'b0, 5'b11_100, 8'hFF);
        check(flash_mask == 8'h10, "R10 flash bit 4 for digit 4", flash_mask, 8'h10);
        bus_read(1'b1, 5'b11_100, v);
        check(v == 8'h45, "R1 char untouched by flash write", v, 8'h45);
        bus_read(1'b0, 5'b01_100, v);
        check(v == 8'h01, "R1 flash read any section bits", v, 1);
        bus_write(1'b0, 5'b10_001, 8'h01);
        bus_write(1'b0, 5'b00_100, 8'hFE);
        check(flash_mask == 8'h02, "R1 flash uses data bit 0 only", flash_mask, 8'h02);
    endtask

    task automatic t_glyph_rows();
        logic [7:0] v;
        bus_write(1'b1, 5'b00_000, 8'hF5);
        bus_read(1'b1, 5'b00_000, v);
        check(v == 8'h05, "R2 pointer holds bits 3..0", v, 5);
        for (int r = 0; r < 7; r++) bus_write(1'b1, {2'b01, 3'(r)}, 8'hE0 | 8'(r * 3 + 1));
        bus_write(1'b1, 5'b01_111, 8'h1F);
        for (int r = 0; r < 7; r++) begin
            bus_read(1'b1, {2'b01, 3'(r)}, v);
            check(v == 8'((r * 3 + 1) & 8'h1F), "R5 glyph row readback", v, (r * 3 + 1) & 8'h1F);
        end
        bus_read(1'b1, 5'b01_111, v);
        check(v == 8'h00, "R5 row address 7 reads 0", v, 0);
        bus_write(1'b1, 5'b00_000, 8'h06);
        bus_write(1'b1, 5'b01_000, 8'h11);
        bus_write(1'b1, 5'b00_000, 8'h05);
        bus_read(1'b1, 5'b01_000, v);
        check(v == 8'h01, "R5 rows are per pointed glyph", v, 1);
    endtask

    task automatic t_cs_gate();
        logic [7:0] v;
        @(negedge clk);
        flash_sel_n = 1'b1; addr = 5'b11_000; data_in = 8'h7E; cs_n = 1'b0; wr_n = 1'b0;
        @(negedge clk); cs_n = 1'b1;
        @(negedge clk); wr_n = 1'b1;
        @(negedge clk);
        bus_read(1'b1, 5'b11_000, v);
        check(v == 8'h41, "R3 no write with cs_n high at edge", v, 8'h41);
        @(negedge clk);
        addr = 5'b11_000; data_in = 8'h5A; cs_n = 1'b0; wr_n = 1'b0;
        repeat (3) @(negedge clk);
        #1 check(data_out == 8'h00 && data_oe == 1'b0, "R4 quiet bus during write", data_out, 0);
        wr_n = 1'b1;
        @(negedge clk); cs_n = 1'b1;
        bus_read(1'b1, 5'b11_000, v);
        check(v == 8'h5A, "R3 write commits on wr_n rise", v, 8'h5A);
    endtask

    task automatic t_output_enable();
        @(negedge clk); cs_n = 1'b0; rd_n = 1'b1;
        #1 check(data_oe == 1'b0, "R4 oe low with rd_n high", data_oe, 0);
        @(negedge clk); cs_n = 1'b1; rd_n = 1'b0;
        #1 check(data_oe == 1'b0, "R4 oe low with cs_n high", data_oe, 0);
        @(negedge clk); cs_n = 1'b0; rd_n = 1'b0;
        #1 check(data_oe == 1'b1, "R4 oe high with both low", data_oe, 1);
        @(negedge clk); cs_n = 1'b1; rd_n = 1'b1;
    endtask

    task automatic t_ctrl_word();
        logic [7:0] v;
        bus_write(1'b1, 5'b10_000, 8'h1B);
        check(ctrl_word == 8'h1B, "R10 ctrl_word output", ctrl_word, 8'h1B);
        bus_read(1'b1, 5'b10_111, v);
        check(v == 8'h1B, "R2 ctrl readback", v, 8'h1B);
    endtask

    task automatic t_clear_and_busy();
        logic [7:0] v;
        bus_write(1'b0, 5'b00_110, 8'h01);
        bus_write(1'b1, 5'b10_000, 8'hD3);
        check(busy == 1'b1, "R7 clear raises busy", busy, 1);
        check(ctrl_word == 8'hD3, "R7 clear bit visible while busy", ctrl_word, 8'hD3);
        check(flash_mask == 8'h00, "R7 flash cleared", flash_mask, 0);
        bus_write(1'b1, 5'b11_001, 8'h33);
        check(wr_err == 1'b1, "R8 write while busy flagged", wr_err, 1);
        expect_busy_window("R7");
        check(ctrl_word == 8'h53, "R7 bit 7 self-clears, rest kept", ctrl_word, 8'h53);
        for (int i = 0; i < 8; i++) begin
            bus_read(1'b1, {2'b11, 3'(i)}, v);
            check(v == 8'h20, "R7/R8 char blank after clear", v, 8'h20);
        end
        bus_write(1'b1, 5'b11_001, 8'h34);
        check(wr_err == 1'b1, "R8 wr_err sticky", wr_err, 1);
    endtask

    task automatic t_reset_keeps_glyphs();
        logic [7:0] v;
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check(wr_err == 1'b0, "R8 reset clears wr_err", wr_err, 0);
        check(ctrl_word == 8'h00, "R6 reset clears ctrl", ctrl_word, 0);
        expect_busy_window("R6 second reset");
        bus_read(1'b1, 5'b00_000, v);
        check(v == 8'h05, "R6 pointer kept over reset", v, 5);
        bus_read(1'b1, 5'b01_010, v);
        check(v == 8'h07, "R6 glyph row kept over reset", v, 7);
        bus_read(1'b1, 5'b11_001, v);
        check(v == 8'h20, "R6 char blank after reset", v, 8'h20);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: got 0x0 expected 0x1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; disp_tick = 1'b0; cs_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1;
        flash_sel_n = 1'b1; addr = '0; data_in = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_char_store();
        t_flash_store();
        t_glyph_rows();
        t_cs_gate();
        t_output_enable();
        t_ctrl_word();
        t_clear_and_busy();
        t_reset_keeps_glyphs();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule